// File: doc/BRIEF.md
# Branch and Jump Target Unit

This unit resolves control transfer for a 64-bit load/store processor. It takes one 32-bit instruction word, the address of that instruction and two register read values. From these it decides whether the instruction redirects fetch, where fetch goes next, and whether a return address must be written back. Each accepted instruction yields one registered result one clock later. Register reads, fetch and prediction are handled elsewhere. The unit only passes the jump hint bits on to the predictor.

The instruction word has the opcode in bits 31:26 and the link or test register index in bits 25:21. Bits 20:0 hold either a 21-bit signed word displacement or, for register-indirect jumps, the target register index in bits 20:16. For jumps, bits 15:14 name one of four variants. All four variants behave the same. Bits 13:0 carry a hint operand. The sequential address is the instruction address plus 4. It is always offered as the link value.

Opcode map: 0x30 is the unconditional relative branch with link, and 0x1A is the register-indirect jump group. Opcodes 0x38 to 0x3F are the conditional branches. Every other opcode is not a control transfer.

Top module: `bru_target_unit`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: A result appears on the outputs one clock after `in_valid` is high, with `out_valid` high. While `in_valid` is low, the result outputs hold their previous values.
- R3: A relative target equals (instruction address + 4) + 4 × sign-extended bits 20:0, computed modulo 2^64. The reach is ±1M instructions from the sequential address.
- R4: Conditional opcodes test the Ra value as a signed 64-bit integer using all 64 bits. The opcodes are: 0x38 low bit clear, 0x39 equal to zero, 0x3A less than zero, 0x3B less or equal to zero, 0x3C low bit set, 0x3D not zero, 0x3E greater or equal to zero, 0x3F greater than zero.
- R5: A conditional branch never requests a link write. When a branch is not taken, `next_pc` equals instruction address + 4.
- R6: Opcode 0x30 is always taken to its relative target. It requests a link write of instruction address + 4 to register Ra.
- R7: Opcode 0x1A is always taken to the Rb value with bits 1:0 cleared. It requests a link write of instruction address + 4 to Ra.
- R8: When Ra and Rb name the same register, the jump target still comes from the Rb value presented with the instruction. The link value leaves that target untouched.
- R9: The four jump variants give identical target, taken and link results. `hint_kind` carries bits 15:14 and `hint_op` carries bits 13:0. Both are zero for every other opcode.
- R10: Any other opcode gives not taken, no link write, and `next_pc` equal to instruction address + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction inputs are valid this cycle |
| instr | input | 32 | Instruction word |
| cur_pc | input | 64 | Address of the instruction |
| ra_val | input | 64 | Value read from register Ra |
| rb_val | input | 64 | Value read from register Rb |
| out_valid | output | 1 | Registered result is present |
| taken | output | 1 | Control transfer redirects fetch |
| next_pc | output | 64 | Address of the next instruction to fetch |
| link_we | output | 1 | Write link value to register `link_idx` |
| link_idx | output | 5 | Destination register of the link value |
| link_val | output | 64 | Instruction address + 4 |
| hint_kind | output | 2 | Jump variant field |
| hint_op | output | 14 | Jump hint operand |

## Verification
A wrong decode class or condition inverts `taken` in the very next cycle. It then shows as `next_pc` equal to `link_val` where a target was due, or the reverse. An error in displacement scaling or sign extension only shows on branches with large or negative displacements. For this reason the vectors include both reach limits and a wrap across the top of the address space. A stale or dropped register in the output stage shows as `out_valid` or held values that do not follow `in_valid` by exactly one cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

  // Class of control transfer decoded from the opcode
  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_COND   = 2'd1,
    CK_UNCOND = 2'd2,
    CK_JUMP   = 2'd3
  } ctl_kind_e;

  // Condition codes equal the low three opcode bits of the conditional group.
  // Bit 2 inverts the base test named by bits 1:0.
  typedef enum logic [2:0] {
    CC_LBC = 3'd0,
    CC_EQ  = 3'd1,
    CC_LT  = 3'd2,
    CC_LE  = 3'd3,
    CC_LBS = 3'd4,
    CC_NE  = 3'd5,
    CC_GE  = 3'd6,
    CC_GT  = 3'd7
  } cond_e;

  localparam logic [5:0] OP_UNCOND   = 6'h30;
  localparam logic [5:0] OP_JUMP     = 6'h1A;
  localparam logic [2:0] OP_COND_HI  = 3'b111;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int IW     = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5,
  parameter int DISP_W = 21,
  parameter int HINT_W = 14,
  parameter int VAR_W  = 2
) (
  input  logic [IW-1:0]     instr,
  output ctl_kind_e         kind,
  output cond_e             cond,
  output logic [REG_W-1:0]  ra_idx,
  output logic [DISP_W-1:0] disp,
  output logic [VAR_W-1:0]  var_sel,
  output logic [HINT_W-1:0] hint_val
);

  localparam int OP_LSB = IW - OP_W;
  localparam int RA_LSB = OP_LSB - REG_W;

  logic [OP_W-1:0] opcode;

  assign opcode   = instr[IW-1:OP_LSB];
  assign ra_idx   = instr[RA_LSB +: REG_W];
  assign disp     = instr[DISP_W-1:0];
  assign var_sel  = instr[HINT_W +: VAR_W];
  assign hint_val = instr[HINT_W-1:0];

  always_comb begin
    kind = CK_NONE;
    cond = cond_e'(opcode[2:0]);
    if (opcode == OP_JUMP)                     kind = CK_JUMP;
    else if (opcode == OP_UNCOND)              kind = CK_UNCOND;
    else if (opcode[OP_W-1:OP_W-3] == OP_COND_HI) kind = CK_COND;
  end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val,
  input  cond_e           cond,
  output logic            pass
);

  // Base test chosen by the low two bits; the high bit inverts it.
  function automatic logic base_test(input logic [XLEN-1:0] v, input logic [1:0] sel);
    logic zero;
    logic neg;
    zero = (v == '0);
    neg  = v[XLEN-1];
    case (sel)
      2'd0:    base_test = ~v[0];        // low bit clear
      2'd1:    base_test = zero;         // equal to zero
      2'd2:    base_test = neg;          // less than zero
      default: base_test = neg | zero;   // less or equal to zero
    endcase
  endfunction

  logic base;

  assign base = base_test(val, cond[1:0]);
  assign pass = base ^ cond[2];

endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 21,
  parameter int INSN_B = 4
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   rb_val,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   rel_target,
  output logic [XLEN-1:0]   ind_target
);

  localparam int SH    = $clog2(INSN_B);
  localparam int EXT_W = XLEN - DISP_W - SH;

  function automatic logic [XLEN-1:0] byte_offset(input logic [DISP_W-1:0] d);
    byte_offset = {{EXT_W{d[DISP_W-1]}}, d, {SH{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] align_down(input logic [XLEN-1:0] v);
    align_down = v & ~XLEN'(INSN_B - 1);
  endfunction

  assign seq_pc     = pc + XLEN'(INSN_B);
  assign rel_target = seq_pc + byte_offset(disp);
  assign ind_target = align_down(rb_val);

endmodule

// File: rtl/bru_target_unit.sv
module bru_target_unit
  import bru_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int IW     = 32,
  parameter int REG_W  = 5,
  parameter int DISP_W = 21,
  parameter int HINT_W = 14,
  parameter int VAR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IW-1:0]     instr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  output logic              out_valid,
  output logic              taken,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [REG_W-1:0]  link_idx,
  output logic [XLEN-1:0]   link_val,
  output logic [VAR_W-1:0]  hint_kind,
  output logic [HINT_W-1:0] hint_op
);

  ctl_kind_e         dec_kind;
  cond_e             dec_cond;
  logic [REG_W-1:0]  dec_ra;
  logic [DISP_W-1:0] dec_disp;
  logic [VAR_W-1:0]  dec_var;
  logic [HINT_W-1:0] dec_hint;
  logic              cond_pass;
  logic [XLEN-1:0]   seq_pc, rel_target, ind_target;

  bru_decode #(
    .IW(IW), .OP_W(6), .REG_W(REG_W), .DISP_W(DISP_W),
    .HINT_W(HINT_W), .VAR_W(VAR_W)
  ) u_dec (
    .instr(instr), .kind(dec_kind), .cond(dec_cond), .ra_idx(dec_ra),
    .disp(dec_disp), .var_sel(dec_var), .hint_val(dec_hint)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .val(ra_val), .cond(dec_cond), .pass(cond_pass)
  );

  bru_target #(.XLEN(XLEN), .DISP_W(DISP_W), .INSN_B(4)) u_tgt (
    .pc(cur_pc), .disp(dec_disp), .rb_val(rb_val),
    .seq_pc(seq_pc), .rel_target(rel_target), .ind_target(ind_target)
  );

  // Combinational resolution
  logic              res_taken;
  logic              res_link;
  logic [XLEN-1:0]   res_next;
  logic [VAR_W-1:0]  res_var;
  logic [HINT_W-1:0] res_hint;

  always_comb begin
    res_taken = 1'b0;
    res_link  = 1'b0;
    res_next  = seq_pc;
    res_var   = '0;
    res_hint  = '0;
    unique case (dec_kind)
      CK_COND: begin
        res_taken = cond_pass;
        if (cond_pass) res_next = rel_target;
      end
      CK_UNCOND: begin
        res_taken = 1'b1;
        res_link  = 1'b1;
        res_next  = rel_target;
      end
      CK_JUMP: begin
        res_taken = 1'b1;
        res_link  = 1'b1;
        res_next  = ind_target;   // taken from the presented Rb value
        res_var   = dec_var;
        res_hint  = dec_hint;
      end
      default: ;
    endcase
  end

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      link_we   <= 1'b0;
      link_idx  <= '0;
      link_val  <= '0;
      hint_kind <= '0;
      hint_op   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken     <= res_taken;
        next_pc   <= res_next;
        link_we   <= res_link;
        link_idx  <= dec_ra;
        link_val  <= seq_pc;
        hint_kind <= res_var;
        hint_op   <= res_hint;
      end
    end
  end

  // Assertions
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(taken) && $stable(link_we)));

  p_nolink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind == CK_COND) |=> !link_we);

  p_fallthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !taken) |-> (next_pc == link_val));

  p_uncond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind == CK_UNCOND) |=> (taken && link_we));

  p_jalign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind == CK_JUMP) |=> (taken && link_we && next_pc[1:0] == 2'b00));

  p_hint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind != CK_JUMP) |=> (hint_kind == '0 && hint_op == '0));

  p_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_kind == CK_NONE) |=> (!taken && !link_we));

endmodule

// File: tb/bru_target_unit_test.sv
module bru_target_unit_test;

  localparam int PERIOD = 10;
  localparam int NV     = 23;

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  ra;
    logic [20:0] low;
    logic [63:0] pc;
    logic [63:0] a;
    logic [63:0] b;
    logic        tk;
    logic        lw;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{6'h39, 5'd1, 21'd5,        64'h1000, 64'h0,                   64'h0, 1'b1, 1'b0},
    '{6'h39, 5'd1, 21'd5,        64'h1000, 64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0},
    '{6'h3D, 5'd2, 21'h1FFFFF,   64'h2000, 64'h1_0000_0000,         64'h0, 1'b1, 1'b0},
    '{6'h3A, 5'd3, 21'd16,       64'h3000, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b0},
    '{6'h3A, 5'd3, 21'd16,       64'h3000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0},
    '{6'h3B, 5'd4, 21'd7,        64'h4000, 64'h0,                   64'h0, 1'b1, 1'b0},
    '{6'h3B, 5'd4, 21'd7,        64'h4000, 64'h1,                   64'h0, 1'b0, 1'b0},
    '{6'h3E, 5'd5, 21'h1FFFF0,   64'h5000, 64'h0,                   64'h0, 1'b1, 1'b0},
    '{6'h3E, 5'd5, 21'h1FFFF0,   64'h5000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b0},
    '{6'h3F, 5'd6, 21'd3,        64'h6000, 64'h1,                   64'h0, 1'b1, 1'b0},
    '{6'h3F, 5'd6, 21'd3,        64'h6000, 64'h0,                   64'h0, 1'b0, 1'b0},
    '{6'h38, 5'd7, 21'd9,        64'h7000, 64'h2,                   64'h0, 1'b1, 1'b0},
    '{6'h3C, 5'd7, 21'd9,        64'h7000, 64'h2,                   64'h0, 1'b0, 1'b0},
    '{6'h3C, 5'd7, 21'd9,        64'h7000, 64'h3,                   64'h0, 1'b1, 1'b0},
    '{6'h30, 5'd26, 21'h0FFFFF,  64'h0,    64'h0,                   64'h0, 1'b1, 1'b1},
    '{6'h30, 5'd26, 21'h100000,  64'h1000_0000, 64'h0,              64'h0, 1'b1, 1'b1},
    '{6'h30, 5'd26, 21'd0,       64'hFFFF_FFFF_FFFF_FFFC, 64'h0,    64'h0, 1'b1, 1'b1},
    '{6'h1A, 5'd26, {5'd7, 2'd0, 14'h0ABC}, 64'h8000, 64'h0, 64'h123457, 1'b1, 1'b1},
    '{6'h1A, 5'd26, {5'd7, 2'd1, 14'h0ABC}, 64'h8000, 64'h0, 64'h123457, 1'b1, 1'b1},
    '{6'h1A, 5'd26, {5'd7, 2'd2, 14'h0ABC}, 64'h8000, 64'h0, 64'h123457, 1'b1, 1'b1},
    '{6'h1A, 5'd26, {5'd7, 2'd3, 14'h3FFF}, 64'h8000, 64'h0, 64'h123457, 1'b1, 1'b1},
    '{6'h10, 5'd8, 21'd100,      64'h9000, 64'h0,                   64'h0, 1'b0, 1'b0},
    '{6'h1A, 5'd9, {5'd9, 2'd2, 14'h0001}, 64'hA000, 64'h55, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] cur_pc = '0, ra_val = '0, rb_val = '0;
  logic        out_valid, taken, link_we;
  logic [63:0] next_pc, link_val;
  logic [4:0]  link_idx;
  logic [1:0]  hint_kind;
  logic [13:0] hint_op;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  bru_target_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .cur_pc(cur_pc), .ra_val(ra_val), .rb_val(rb_val),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .hint_kind(hint_kind), .hint_op(hint_op)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent model of the expected next address
  function automatic logic [63:0] model_next(input vec_t v);
    longint d;
    if (v.op == 6'h1A) return {v.b[63:2], 2'b00};
    if (!v.tk) return v.pc + 64'd4;
    d = v.low[20] ? longint'(v.low) - 64'sd2097152 : longint'(v.low);
    return v.pc + 64'd4 + 64'(d * 4);
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    instr    = {v.op, v.ra, v.low};
    cur_pc   = v.pc;
    ra_val   = v.a;
    rb_val   = v.b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired: actual=%h expected=%h", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] keep_pc;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && taken == 0 && link_we == 0, "R1", "reset flags",
        {61'd0, out_valid, taken, link_we}, 64'd0);
    chk(next_pc == 0 && link_val == 0, "R1", "reset next_pc", next_pc, 64'd0);
    chk(hint_kind == 0 && hint_op == 0 && link_idx == 0, "R1", "reset hint",
        {48'd0, hint_kind, hint_op}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk(out_valid == 1'b1, "R2", $sformatf("v%0d out_valid", i), {63'd0, out_valid}, 64'd1);
      chk(taken == VEC[i].tk, "R4", $sformatf("v%0d taken", i), {63'd0, taken}, {63'd0, VEC[i].tk});
      chk(next_pc == model_next(VEC[i]), "R3", $sformatf("v%0d next_pc", i), next_pc, model_next(VEC[i]));
      chk(link_we == VEC[i].lw, "R5", $sformatf("v%0d link_we", i), {63'd0, link_we}, {63'd0, VEC[i].lw});
      chk(link_val == VEC[i].pc + 64'd4, "R6", $sformatf("v%0d link_val", i), link_val, VEC[i].pc + 64'd4);
      chk(link_idx == VEC[i].ra, "R6", $sformatf("v%0d link_idx", i), {59'd0, link_idx}, {59'd0, VEC[i].ra});
      if (VEC[i].op == 6'h1A)
        chk(hint_kind == VEC[i].low[15:14] && hint_op == VEC[i].low[13:0], "R9",
            $sformatf("v%0d hint", i), {48'd0, hint_kind, hint_op}, {48'd0, VEC[i].low[15:0]});
      else
        chk(hint_kind == 0 && hint_op == 0, "R9", $sformatf("v%0d hint zero", i),
            {48'd0, hint_kind, hint_op}, 64'd0);
    end

    // R3 reach limits, hand-computed
    apply(VEC[14]);
    chk(next_pc == 64'h40_0000, "R3", "forward reach", next_pc, 64'h40_0000);
    apply(VEC[15]);
    chk(next_pc == 64'h0FC0_0004, "R3", "backward reach", next_pc, 64'h0FC0_0004);
    apply(VEC[16]);
    chk(next_pc == 64'h0, "R3", "wrap", next_pc, 64'h0);

    // R8: Ra and Rb name register 9; target from presented Rb value
    apply(VEC[22]);
    chk(next_pc == 64'hFFFF_FFFF_FFFF_FFFC, "R8", "same-reg target", next_pc, 64'hFFFF_FFFF_FFFF_FFFC);
    chk(link_val == 64'hA004 && link_idx == 5'd9, "R8", "same-reg link", link_val, 64'hA004);

    // R7: jump low bits cleared
    apply(VEC[17]);
    chk(next_pc == 64'h12_3454, "R7", "jump align", next_pc, 64'h12_3454);

    // R2: hold while in_valid low
    keep_pc = next_pc;
    instr  = {6'h30, 5'd1, 21'd50};
    cur_pc = 64'hDEAD_0000;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid drops", {63'd0, out_valid}, 64'd0);
    chk(next_pc == keep_pc && taken == 1'b1, "R2", "hold next_pc", next_pc, keep_pc);

    // R10 and R5 not-taken fall-through
    apply(VEC[21]);
    chk(!taken && !link_we && next_pc == 64'h9004, "R10", "other opcode", next_pc, 64'h9004);
    apply(VEC[4]);
    chk(next_pc == 64'h3004 && !link_we, "R5", "not taken seq", next_pc, 64'h3004);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk(next_pc == 0 && !taken && !out_valid, "R1", "re-reset", next_pc, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule